// File: doc/BRIEF.md
# Transmit Checksum Insertion Stage

This stage sits in the transmit byte path ahead of the MAC. Each frame is announced by a short control header on a 32-bit sideband stream. The header tells the stage whether to compute a checksum, from which byte to start summing, where to write the result, and which 16-bit seed to add. The frame bytes then arrive on an 8-bit stream with a last flag.

While the bytes arrive, the stage stores them and keeps a running ones'-complement sum of the covered bytes, taken as big-endian 16-bit words. The write position may lie before the end of the summed range, so the whole frame is held in an internal buffer. When the frame is complete, the stage checks it against the transmit configuration. It then either discards the frame or replays it on the output stream with the two checksum bytes substituted.

A configuration register holds the transmit-enable, jumbo and VLAN-length bits. Every frame that is sent adds its length to a 64-bit byte counter and raises a sticky completion flag.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset the configuration reads 0x5800_0000 (bit 30 jumbo, bit 28 transmit enable, bit 27 VLAN length allowed). The byte counter is zero, the completion flag is low, `ctl_ready` is high and `m_valid` is low.
- R2: Every frame is preceded by exactly five 32-bit control words. Bit 0 of word 0 enables insertion. Word 1 carries the start offset in bits 31:16 and the write offset in bits 15:0. Bits 15:0 of word 2 are the seed. All other bits and words 3 and 4 have no effect. `s_ready` stays low until the fifth word is accepted.
- R3: The checksum is computed as follows. Bytes from the start offset to the end of the frame are paired as big-endian 16-bit words, and an odd final byte is padded with a zero low byte. These words are summed, the seed is added, the total is folded to 16 bits with end-around carry, and the result is complemented. If the start offset is at or beyond the frame end, only the seed is folded.
- R4: With insertion enabled, the high checksum byte replaces the byte at the write offset and the low byte replaces the byte at write offset + 1. A position at or beyond the frame end is not written. All other bytes leave unchanged. With insertion disabled the frame leaves unchanged.
- R5: A frame that completes while configuration bit 28 is clear is discarded. It produces no output, no counter change and no completion flag.
- R6: While bit 30 is clear and bit 27 is clear, a frame of 1519 to 1522 bytes inclusive is discarded. Every other length is sent.
- R7: Each sent frame adds its length to the 64-bit byte counter and sets the completion flag. The flag holds until `txc_ack` is pulsed, and a new completion in the same cycle wins over the acknowledge.
- R8: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold. `m_last` marks the final byte of each sent frame.
- R9: Bytes beyond BUF_DEPTH (default 4096) are discarded. The frame is treated as BUF_DEPTH bytes long for summing, the length rule, output and counting.
- R10: A configuration write replaces the whole register, and the new value governs frames that complete afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Current configuration |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted |
| ctl_data | input | 32 | Control word |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Final input byte of frame |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte taken |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final output byte of frame |
| tx_bytes | output | 64 | Total bytes of sent frames |
| txc_pending | output | 1 | Sticky frame-sent flag |
| txc_ack | input | 1 | Clears the frame-sent flag |

## Verification
The embedded assertions guard several properties on every cycle. They check that output data and the last flag hold under back-pressure. They check that the byte counter moves only on the final output transfer, and then by exactly the buffered length. They check that a frame completing with transmit disabled never starts output, that the configuration changes only on a write, and that the running sum changes only on an accepted byte or a header phase. The scenarios alone show the checksum value and its placement, including odd start offsets, odd lengths, write offsets at or past the frame end, and the seed-only case. The length-window rule, truncation at the buffer depth and the acknowledge behaviour of the completion flag are likewise shown only by scenarios, compared against a byte-level model in the bench.

// File: rtl/tcsum_pkg.sv
package tcsum_pkg;
    typedef enum logic [1:0] {
        ST_HDR    = 2'd0,
        ST_FILL   = 2'd1,
        ST_DECIDE = 2'd2,
        ST_DRAIN  = 2'd3
    } tc_state_e;

    localparam int          CFG_VLAN_BIT  = 27;
    localparam int          CFG_TXEN_BIT  = 28;
    localparam int          CFG_JUMBO_BIT = 30;
    localparam logic [31:0] CFG_RESET_VAL = 32'h5800_0000;

    localparam int HDR_WORDS = 5;
    localparam int STD_MAX   = 1518;
    localparam int TAG_MAX   = 1522;
endpackage

// File: rtl/tcsum_cfg_reg.sv
module tcsum_cfg_reg
    import tcsum_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] cfg
);
    logic [31:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET_VAL;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R10: configuration changes only through a write
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/tcsum_frame_buf.sv
module tcsum_frame_buf #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tcsum_accum.sv
module tcsum_accum #(
    parameter int IDX_W = 13,
    localparam int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_val,
    input  logic [15:0]      start_off,
    input  logic [15:0]      seed,
    output logic [15:0]      csum
);
    logic [SUM_W-1:0] sum_d, sum_q;
    logic             in_range;
    logic             hi_half;
    logic [SUM_W-1:0] addend;
    logic [SUM_W-1:0] total;
    logic [16:0]      fold1;
    logic [16:0]      fold2;

    always_comb begin
        in_range = 32'(byte_idx) >= 32'(start_off);
        hi_half  = (byte_idx[0] ^ start_off[0]) == 1'b0;
        addend   = hi_half ? SUM_W'({byte_val, 8'h00}) : SUM_W'(byte_val);
        sum_d    = sum_q;
        if (clear)                     sum_d = '0;
        else if (byte_vld && in_range) sum_d = sum_q + addend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    always_comb begin
        total = sum_q + SUM_W'(seed);
        fold1 = 17'(total[15:0]) + 17'(total[31:16]);
        fold2 = 17'(fold1[15:0]) + 17'(fold1[16]);
        csum  = ~fold2[15:0];
    end

    // R3: the running sum moves only on an accepted byte or a clear
    assert_sum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !byte_vld) |=> $stable(sum_q));
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
    import tcsum_pkg::*;
#(
    parameter int BUF_DEPTH = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        ctl_valid,
    output logic        ctl_ready,
    input  logic [31:0] ctl_data,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [7:0]  m_data,
    output logic        m_last,
    output logic [63:0] tx_bytes,
    output logic        txc_pending,
    input  logic        txc_ack
);
    localparam int AW    = $clog2(BUF_DEPTH);
    localparam int IDX_W = AW + 1;

    typedef struct packed {
        tc_state_e        st;
        logic [2:0]       hcnt;
        logic             ins;
        logic [15:0]      start;
        logic [15:0]      wr;
        logic [15:0]      seed;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] rd;
        logic [63:0]      bytes;
        logic             txc;
    } ins_reg_t;

    ins_reg_t r_d, r_q;

    logic [31:0] cfg;
    logic [15:0] csum;
    logic [7:0]  rd_byte;
    logic        room;
    logic        store;
    logic        last_c;
    logic        drop_c;
    logic        done_c;
    logic        hit_hi;
    logic        hit_lo;

    tcsum_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    tcsum_frame_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .we    (store),
        .waddr (r_q.idx[AW-1:0]),
        .wdata (s_data),
        .raddr (r_q.rd[AW-1:0]),
        .rdata (rd_byte)
    );

    tcsum_accum #(.IDX_W(IDX_W)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (r_q.st == ST_HDR),
        .byte_vld  (store),
        .byte_idx  (r_q.idx),
        .byte_val  (s_data),
        .start_off (r_q.start),
        .seed      (r_q.seed),
        .csum      (csum)
    );

    always_comb begin
        room   = r_q.idx < IDX_W'(BUF_DEPTH);
        store  = (r_q.st == ST_FILL) && s_valid && room;
        last_c = r_q.rd == (r_q.idx - 1'b1);
        drop_c = !cfg[CFG_TXEN_BIT] ||
                 (!cfg[CFG_JUMBO_BIT] && !cfg[CFG_VLAN_BIT] &&
                  (32'(r_q.idx) > 32'(STD_MAX)) && (32'(r_q.idx) <= 32'(TAG_MAX)));
        done_c = (r_q.st == ST_DRAIN) && m_ready && last_c;
        hit_hi = r_q.ins && (32'(r_q.rd) == 32'(r_q.wr));
        hit_lo = r_q.ins && (32'(r_q.rd) == 32'(r_q.wr) + 32'd1);

        r_d = r_q;
        case (r_q.st)
            ST_HDR: begin
                if (ctl_valid) begin
                    case (r_q.hcnt)
                        3'd0: r_d.ins = ctl_data[0];
                        3'd1: begin
                            r_d.start = ctl_data[31:16];
                            r_d.wr    = ctl_data[15:0];
                        end
                        3'd2: r_d.seed = ctl_data[15:0];
                        default: ;
                    endcase
                    if (r_q.hcnt == 3'(HDR_WORDS - 1)) begin
                        r_d.hcnt = '0;
                        r_d.idx  = '0;
                        r_d.st   = ST_FILL;
                    end else begin
                        r_d.hcnt = r_q.hcnt + 3'd1;
                    end
                end
            end
            ST_FILL: begin
                if (s_valid) begin
                    if (room)   r_d.idx = r_q.idx + 1'b1;
                    if (s_last) r_d.st  = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                r_d.rd = '0;
                r_d.st = drop_c ? ST_HDR : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (m_ready) begin
                    r_d.rd = r_q.rd + 1'b1;
                    if (last_c) begin
                        r_d.st    = ST_HDR;
                        r_d.bytes = r_q.bytes + 64'(r_q.idx);
                    end
                end
            end
            default: r_d.st = ST_HDR;
        endcase

        if (txc_ack) r_d.txc = 1'b0;
        if (done_c)  r_d.txc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_rdata   = cfg;
    assign ctl_ready   = r_q.st == ST_HDR;
    assign s_ready     = r_q.st == ST_FILL;
    assign m_valid     = r_q.st == ST_DRAIN;
    assign m_last      = m_valid && last_c;
    assign m_data      = hit_hi ? csum[15:8] : (hit_lo ? csum[7:0] : rd_byte);
    assign tx_bytes    = r_q.bytes;
    assign txc_pending = r_q.txc;

    // R8: output holds under back-pressure
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R7: counter steps by the buffered length on the final transfer
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> (tx_bytes == $past(tx_bytes) + 64'($past(r_q.idx))));

    // R7: counter idle otherwise
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_valid && m_ready && m_last) |=> $stable(tx_bytes));

    // R5: a frame completing with transmit disabled never reaches the output
    assert_drop_txen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_DECIDE) && !cfg[CFG_TXEN_BIT]) |=> (!m_valid && ctl_ready));

    // R9: buffered length never exceeds the buffer depth
    assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(r_q.idx) <= 32'(BUF_DEPTH));

    // R2: no output while a header is being collected
    assert_hdr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ready |-> !m_valid);
endmodule

// File: tb/tx_csum_insert_tb_top.sv
module tx_csum_insert_tb_top;
    localparam int DEPTH = 4096;
    localparam int MAXF  = 4200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ctl_valid = 1'b0;
    logic        ctl_ready;
    logic [31:0] ctl_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [7:0]  m_data;
    logic        m_last;
    logic [63:0] tx_bytes;
    logic        txc_pending;
    logic        txc_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] exp_bytes = '0;
    logic [31:0] cur_cfg = 32'h5800_0000;

    logic [7:0] fr   [MAXF];
    logic [7:0] expf [MAXF];
    logic [7:0] got  [MAXF];

    always #2.5 clk = ~clk;

    tx_csum_insert dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .tx_bytes(tx_bytes), .txc_pending(txc_pending), .txc_ack(txc_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_csum(input int len, input int start, input logic [15:0] seed);
        logic [31:0] s = 0;
        for (int i = start; i < len; i++)
            s += ((i - start) % 2 == 0) ? {16'h0, fr[i], 8'h00} : {24'h0, fr[i]};
        s += {16'h0, seed};
        while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        return ~s[15:0];
    endfunction

    function automatic bit ref_drop(input logic [31:0] c, input int len);
        if (!c[28]) return 1;
        if (!c[30] && !c[27] && len > 1518 && len <= 1522) return 1;
        return 0;
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_cfg = v;
        chk(cfg_rdata == v, "R10", "config readback", cfg_rdata, v);
    endtask

    task automatic run_frame(input bit ins, input int start, input int wr,
                             input logic [15:0] seed, input int len);
        logic [31:0] w [5];
        int eff, got_n;
        bit drop, done, bad, stall, stall_bad;
        logic [7:0] prev_d;
        logic [15:0] cs;
        w[0] = {$urandom() & 32'hFFFF_FFFE} | {31'h0, ins};
        w[1] = {start[15:0], wr[15:0]};
        w[2] = {$urandom() & 32'hFFFF_0000} | {16'h0, seed};
        w[3] = $urandom();
        w[4] = $urandom();
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom());
        eff  = (len > DEPTH) ? DEPTH : len;
        drop = ref_drop(cur_cfg, eff);
        cs   = ref_csum(eff, start, seed);
        for (int i = 0; i < eff; i++) expf[i] = fr[i];
        if (ins && wr < eff) expf[wr] = cs[15:8];
        if (ins && wr + 1 < eff) expf[wr + 1] = cs[7:0];

        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (k == 4) chk(!s_ready, "R2", "s_ready low before fifth word", s_ready, 0);
            ctl_valid = 1'b1; ctl_data = w[k];
            while (!ctl_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        ctl_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            while ($urandom() % 5 == 0) begin
                s_valid = 1'b0;
                @(negedge clk);
            end
            s_valid = 1'b1; s_data = fr[i]; s_last = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;

        if (drop) begin
            bad = 0;
            for (int c = 0; c < 8; c++) begin
                if (m_valid) bad = 1;
                @(negedge clk);
            end
            chk(!bad && ctl_ready, "R5 R6", "dropped frame emitted nothing", bad, 0);
            chk(tx_bytes == exp_bytes, "R5 R6", "counter unchanged on drop", tx_bytes, exp_bytes);
            chk(!txc_pending, "R5 R6", "no completion on drop", txc_pending, 0);
            return;
        end

        got_n = 0; done = 0; stall = 0; stall_bad = 0; prev_d = '0;
        while (!done) begin
            if (stall && (!m_valid || m_data != prev_d)) stall_bad = 1;
            stall = 0;
            m_ready = ($urandom() % 4 != 0);
            if (m_valid && !m_ready) begin
                stall = 1; prev_d = m_data;
            end
            if (m_valid && m_ready) begin
                if (got_n < MAXF) got[got_n] = m_data;
                got_n++;
                if (m_last) done = 1;
            end
            @(negedge clk);
        end
        m_ready = 1'b0;
        exp_bytes += 64'(eff);
        chk(!stall_bad, "R8", "data stable while stalled", stall_bad, 0);
        chk(got_n == eff, "R8 R9", "output length with last flag", got_n, eff);
        bad = 0;
        for (int i = 0; i < eff && i < got_n; i++) begin
            if (!bad && got[i] != expf[i]) begin
                bad = 1;
                chk(0, "R3 R4", $sformatf("byte %0d", i), got[i], expf[i]);
            end
        end
        if (!bad) chk(1, "R3 R4", "frame content", 0, 0);
        chk(tx_bytes == exp_bytes, "R7", "byte counter", tx_bytes, exp_bytes);
        chk(txc_pending, "R7", "completion flag set", txc_pending, 1);
        txc_ack = 1'b1;
        @(negedge clk);
        txc_ack = 1'b0;
        chk(!txc_pending, "R7", "completion flag cleared by ack", txc_pending, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 32'h5800_0000, "R1", "reset config", cfg_rdata, 32'h5800_0000);
        chk(tx_bytes == 0, "R1", "reset counter", tx_bytes, 0);
        chk(!txc_pending, "R1", "reset flag", txc_pending, 0);
        chk(ctl_ready && !m_valid && !s_ready, "R1", "reset handshakes", {ctl_ready, m_valid, s_ready}, 3'b100);

        run_frame(1, 14, 30, 16'h1234, 60);       // R3 R4 even start
        run_frame(1, 15, 59, 16'hFFFF, 61);       // R3 odd start, odd length
        run_frame(1, 0, 39, 16'h0001, 40);        // R4 only high byte fits
        run_frame(1, 0, 100, 16'h0BAD, 50);       // R4 write offset past end
        run_frame(0, 2, 4, 16'h5555, 33);         // R4 insertion disabled
        run_frame(1, 80, 3, 16'hA5A5, 70);        // R3 seed only
        run_frame(1, 0, 0, 16'h0000, 1);          // single byte frame
        for (int n = 0; n < 15; n++) begin
            int l = 1 + ($urandom() % 200);
            run_frame($urandom() % 2, $urandom() % (l + 4), $urandom() % (l + 2),
                      16'($urandom()), l);
        end

        write_cfg(32'h4800_0000);                 // R5 transmit disabled
        run_frame(1, 0, 5, 16'h0, 64);
        write_cfg(32'h1000_0000);                 // R6 strict length window
        run_frame(1, 14, 20, 16'h1, 1520);
        run_frame(1, 14, 20, 16'h1, 1522);
        run_frame(1, 14, 20, 16'h1, 1518);
        run_frame(1, 14, 20, 16'h1, 1523);
        write_cfg(32'h1800_0000);                 // R6 VLAN length allowed
        run_frame(1, 14, 20, 16'h1, 1520);
        write_cfg(32'h5800_0000);                 // R9 truncation
        run_frame(1, 1, 4094, 16'h7777, 4100);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule